// File: doc/BRIEF.md
# RS-485 Driver-Enable Sequencer

This block generates the direction signal for a half-duplex RS-485 transceiver. It uses the status of a UART transmitter to decide when the line driver may be on. When a character is waiting, the block raises the driver enable and holds it for at least one bit tick. Only then does it grant the transmitter permission to start, so the first start bit never goes out on an undriven bus. The enable stays on without a gap while characters follow one another.

After the final stop bit of the last waiting character, the enable is released. This happens either on the next clock, or after a programmable turnaround hold of 1 to 15 bit times, which lets the last bit reach distant nodes. If new data appears during the hold, the hold is abandoned and the driver stays on. A polarity bit selects whether the pin is active high or active low. With the feature switched off, the pin carries its ordinary general-purpose output value and the transmitter is never held back.

Top module: `rs485_dir_seq`

## Requirements
- R1: After reset, with the feature on, the direction pin sits at its inactive level (equal to `cfg_pol`) and `tx_grant` is 0.
- R2: `tx_pending` high while idle makes the pin active on the next clock. `tx_grant` stays 0 until a `bit_tick` has been seen with the pin active, and it goes to 1 on the clock after that tick.
- R3: A `stop_done` strobe with `tx_pending` low and `cfg_delay` = 0 makes the pin inactive on the next clock.
- R4: A `stop_done` strobe with `tx_pending` low and `cfg_delay` = D (1..15) keeps the pin active until the D-th following `bit_tick`, and the pin goes inactive on the clock that samples that tick. Clocks without a tick do not shorten the hold.
- R5: A `stop_done` strobe while `tx_pending` is high keeps the pin active and `tx_grant` at 1 (back-to-back characters).
- R6: `tx_pending` going high during the hold cancels it: the pin never shows the inactive level, and `tx_grant` returns to 1 on the next clock.
- R7: `cfg_pol` = 1 inverts the pin: active is 0 and inactive is 1. `cfg_pol` = 0 makes active 1.
- R8: With `cfg_en` = 0, `dir_out` equals `gpio_in`, `tx_grant` is 1 and `tx_pending` has no effect. Clearing `cfg_en` returns the sequencer to idle, so re-enabling with nothing pending gives the inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Feature switch; 0 passes `gpio_in` to the pin |
| cfg_pol | input | 1 | 1 makes the pin active low |
| cfg_delay | input | DLY_W | Turnaround hold in bit times, 0 for none |
| gpio_in | input | 1 | Ordinary output value used when the feature is off |
| tx_pending | input | 1 | Transmitter has a character waiting or in flight |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| stop_done | input | 1 | One-cycle pulse when a stop bit has finished |
| tx_grant | output | 1 | Transmitter may start a character |
| dir_out | output | 1 | Transceiver direction pin |

## Verification
A sequencer stuck in the wrong state shows at the pin within one clock of the event that should have moved it. It may release the driver while data is still waiting, keep driving after the hold has run out, or grant the transmitter before the setup tick. A hold counter that is off by one shifts the release by exactly one bit tick. The bench therefore samples the pin on every tick of every hold length it tries, at both polarities. Cancelling the hold and passing characters back to back are both checked cycle by cycle, since a one-cycle drop of the enable would corrupt a frame without leaving any trace in state.

// File: rtl/rs485_seq_pkg.sv
package rs485_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_HOLD   = 2'd3
  } seq_state_e;

  // Pin level for a given logical drive state and polarity selection.
  function automatic logic pin_level(input logic drive, input logic invert);
    return drive ^ invert;
  endfunction

endpackage

// File: rtl/rs485_hold_cnt.sv
module rs485_hold_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (load)                  cnt_q <= load_val;
    else if (dec && cnt_q != '0)    cnt_q <= cnt_q - ONE;
  end

  assign last = (cnt_q == ONE);

  // R4: each qualifying tick removes exactly one bit time
  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));

endmodule

// File: rtl/rs485_dir_fsm.sv
module rs485_dir_fsm
  import rs485_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_en,
  input  logic       tx_pending,
  input  logic       bit_tick,
  input  logic       stop_done,
  input  logic       dly_zero,
  input  logic       hold_last,
  output seq_state_e st,
  output logic       ev_hold_load,
  output logic       ev_hold_tick
);
  seq_state_e st_q, st_d;

  logic ev_last_stop;
  assign ev_last_stop = (st_q == ST_ACTIVE) && stop_done && !tx_pending;
  assign ev_hold_load = cfg_en && ev_last_stop && !dly_zero;
  assign ev_hold_tick = (st_q == ST_HOLD) && bit_tick;

  always_comb begin
    st_d = st_q;
    if (!cfg_en) st_d = ST_IDLE;
    else begin
      unique case (st_q)
        ST_IDLE:   if (tx_pending) st_d = ST_SETUP;
        ST_SETUP:  if (bit_tick)   st_d = tx_pending ? ST_ACTIVE : ST_IDLE;
        ST_ACTIVE: if (ev_last_stop) st_d = dly_zero ? ST_IDLE : ST_HOLD;
        ST_HOLD: begin
          if (tx_pending)                 st_d = ST_ACTIVE;
          else if (bit_tick && hold_last) st_d = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign st = st_q;

  // R2: transmission grant is only reached through the setup or hold states
  a_r2_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACTIVE && $past(st_q) != ST_ACTIVE) |->
      ($past(st_q) == ST_SETUP || $past(st_q) == ST_HOLD));

  // R3: zero delay releases on the next clock
  a_r3_instant_release: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && st_q == ST_ACTIVE && stop_done && !tx_pending && dly_zero)
      |=> (st_q == ST_IDLE));

  // R5: back-to-back characters keep the driver on
  a_r5_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && st_q == ST_ACTIVE && stop_done && tx_pending)
      |=> (st_q == ST_ACTIVE));

  // R6: new data during hold cancels it with no idle cycle
  a_r6_hold_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && st_q == ST_HOLD && tx_pending) |=> (st_q == ST_ACTIVE));

endmodule

// File: rtl/rs485_dir_seq.sv
module rs485_dir_seq
  import rs485_seq_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_pol,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic             gpio_in,
  input  logic             tx_pending,
  input  logic             bit_tick,
  input  logic             stop_done,
  output logic             tx_grant,
  output logic             dir_out
);
  seq_state_e st;
  logic ev_hold_load, ev_hold_tick, hold_last, dly_zero, drive;

  assign dly_zero = (cfg_delay == '0);

  rs485_dir_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_en       (cfg_en),
    .tx_pending   (tx_pending),
    .bit_tick     (bit_tick),
    .stop_done    (stop_done),
    .dly_zero     (dly_zero),
    .hold_last    (hold_last),
    .st           (st),
    .ev_hold_load (ev_hold_load),
    .ev_hold_tick (ev_hold_tick)
  );

  rs485_hold_cnt #(.W(DLY_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_hold_load),
    .load_val (cfg_delay),
    .dec      (ev_hold_tick),
    .last     (hold_last)
  );

  assign drive    = (st != ST_IDLE);
  assign tx_grant = cfg_en ? (st == ST_ACTIVE) : 1'b1;
  assign dir_out  = cfg_en ? pin_level(drive, cfg_pol) : gpio_in;

endmodule

// File: tb/rs485_dir_seq_tb.sv
module rs485_dir_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {polarity, delay}
  localparam logic [4:0] VEC [0:NVEC-1] = '{5'h00, 5'h01, 5'h05, 5'h13, 5'h1F, 5'h0F};

  logic clk = 0, rst_n = 0;
  logic cfg_en = 1, cfg_pol = 0, gpio_in = 0;
  logic [3:0] cfg_delay = 0;
  logic tx_pending = 0, bit_tick = 0, stop_done = 0;
  logic tx_grant, dir_out;
  int checks = 0, errors = 0;
  logic done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rs485_dir_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_pol(cfg_pol),
    .cfg_delay(cfg_delay), .gpio_in(gpio_in), .tx_pending(tx_pending),
    .bit_tick(bit_tick), .stop_done(stop_done), .tx_grant(tx_grant),
    .dir_out(dir_out)
  );

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Raise the pending flag and pass the setup tick; leaves the grant open.
  task automatic start_tx(input logic pol);
    tx_pending = 1; step();
    chk("R2 pin active after request", dir_out, ~pol);
    chk("R2 no grant before tick", tx_grant, 1'b0);
    step();
    chk("R2 no grant without tick", tx_grant, 1'b0);
    bit_tick = 1; step(); bit_tick = 0;
    chk("R2 grant after tick", tx_grant, 1'b1);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1; step();
    chk("R1 reset pin inactive", dir_out, 1'b0);
    chk("R1 reset no grant", tx_grant, 1'b0);

    for (int v = 0; v < NVEC; v++) begin
      logic pol; logic [3:0] d;
      pol = VEC[v][4]; d = VEC[v][3:0];
      cfg_pol = pol; cfg_delay = d; step();
      chk("R7 idle level follows polarity", dir_out, pol);
      start_tx(pol);
      tx_pending = 0; stop_done = 1; step(); stop_done = 0;
      if (d == 0) chk("R3 instant release", dir_out, pol);
      else begin
        for (int t = 0; t < int'(d); t++) begin
          chk("R4 held before tick", dir_out, ~pol);
          step();
          chk("R4 held on idle clock", dir_out, ~pol);
          bit_tick = 1; step(); bit_tick = 0;
        end
        chk("R4 released after last tick", dir_out, pol);
      end
      step();
      chk("R1 back to idle", dir_out, pol);
    end

    // Back-to-back characters and hold cancel
    cfg_pol = 0; cfg_delay = 4'd3; step();
    start_tx(1'b0);
    stop_done = 1; step(); stop_done = 0;
    chk("R5 pin stays active", dir_out, 1'b1);
    chk("R5 grant stays", tx_grant, 1'b1);
    tx_pending = 0; stop_done = 1; step(); stop_done = 0;
    chk("R4 hold entered", dir_out, 1'b1);
    chk("R6 no grant in hold", tx_grant, 1'b0);
    bit_tick = 1; step(); bit_tick = 0;
    chk("R4 hold after one tick", dir_out, 1'b1);
    tx_pending = 1; step();
    chk("R6 pin stays active on cancel", dir_out, 1'b1);
    chk("R6 grant restored", tx_grant, 1'b1);
    tx_pending = 0; stop_done = 1; step(); stop_done = 0;
    for (int t = 0; t < 3; t++) begin
      chk("R6 full hold reloaded", dir_out, 1'b1);
      bit_tick = 1; step(); bit_tick = 0;
    end
    chk("R6 release after reloaded hold", dir_out, 1'b0);

    // Feature off
    cfg_en = 0; gpio_in = 1; step();
    chk("R8 pin follows gpio high", dir_out, 1'b1);
    chk("R8 grant open", tx_grant, 1'b1);
    gpio_in = 0; tx_pending = 1; step();
    chk("R8 pending ignored", dir_out, 1'b0);
    cfg_en = 1; tx_pending = 1; step();
    chk("R8 setup after enable", dir_out, 1'b1);
    cfg_en = 0; step();
    cfg_en = 1; tx_pending = 0; step();
    chk("R8 disable returns to idle", dir_out, 1'b0);
    chk("R8 no grant after re-enable", tx_grant, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule